// File: doc/BRIEF.md
# Two-Axis Sample Sequence Player

This block is a bus slave with an AHB-Lite style interface. It holds two short tables of signed 16-bit points, one for the horizontal axis and one for the vertical axis. It plays both tables back together at a rate that software programs. A two-axis scanner or deflection stage can use the pair of output words as its position command.

Software first sets a load flag. It then pushes points into each table through a fixed port address, one write per point, with a separate fill pointer for each axis. Software then clears the load flag. To start playback it writes the control word with the run flag set and the number of points packed into its top bits. A divider counts clock cycles. Each time the divider expires, the block presents the point at the shared play pointer on both outputs and moves the pointer on. The pointer wraps at the end of the programmed length. Clearing the run flag freezes the pointer and the outputs.

Top module: `xyp_player`

## Requirements
- R1: After reset, both outputs are zero, every register reads zero, both tables hold zero, `hready` is 1 and `hresp` is 0.
- R2: The control word sits at word index 0, which is taken from `haddr[3:2]`. Bit 0 is run, bit 1 is load and bit 2 is the interpolation select; the interpolation select is only stored. The point count is the field `[31:26]`, where 0 means 64 points. The word reads back exactly as last written.
- R3: The speed word sits at word index 1 and reads back exactly as last written. Its low 16 bits are the period P in clock cycles, with P = 0 treated as 1.
- R4: Reads of word index 2 (X port) or word index 3 (Y port) return zero.
- R5: A transfer takes effect only when `hsel` is 1 and `htrans` is 2'b10 or 2'b11 in the address phase. Write data is taken from `hwdata` on the next cycle, and `hrdata` is valid during that same data phase. IDLE transfers change nothing.
- R6: While the load bit is 1, each write to the X port stores `hwdata[15:0]` into the next X slot. The Y port does the same for Y, with its own fill pointer. A control write that moves the load bit from 0 to 1 returns both fill pointers to slot 0.
- R7: Writes to either port while the load bit is 0 leave both tables and both fill pointers unchanged.
- R8: On each advance, `x_out` and `y_out` take the points at the play pointer. The pointer then steps by one, and returns to 0 after the last point of the programmed count.
- R9: Run and speed take effect from the clock edge after the data-phase edge that writes them. With run set, the first advance is on the P-th edge after that write edge, and every P edges after that.
- R10: While run is 0, the outputs and the play pointer hold and the divider is cleared. Setting run again continues from the held pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select, address phase |
| haddr | input | 8 | Byte address; bits 3:2 pick the word |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, address phase |
| hwdata | input | 32 | Write data, data phase |
| hrdata | output | 32 | Read data, data phase |
| hready | output | 1 | Always 1, no wait states |
| hresp | output | 1 | Always 0, OKAY |
| x_out | output | 16 | Current horizontal point, two's complement |
| y_out | output | 16 | Current vertical point, two's complement |

## Verification
The assertions assume that the master completes every transfer in two cycles with no back-pressure. They also assume that a port write never lands in the same data phase as a control write, which the bus enforces because a data phase carries a single address. The properties on the play pointer assume the point count is not changed while run is 1. The bench therefore programs the count and the speed only while playback is stopped, and it sends every transfer as an isolated NONSEQ or IDLE phase followed by its data phase.

// File: rtl/xyp_pkg.sv
package xyp_pkg;

  localparam int NUM_AXES = 2;

  typedef enum logic [1:0] {
    WORD_CTRL  = 2'd0,
    WORD_SPEED = 2'd1,
    WORD_XPORT = 2'd2,
    WORD_YPORT = 2'd3
  } xyp_word_e;

  localparam int BIT_RUN    = 0;
  localparam int BIT_LOAD   = 1;
  localparam int BIT_INTERP = 2;

  // Effective count: a zero field selects the whole table.
  function automatic logic [31:0] eff_count(logic [31:0] field, logic [31:0] depth);
    return (field == 32'd0) ? depth : field;
  endfunction

  // Play pointer step with wrap after the last point.
  function automatic logic [31:0] step_index(logic [31:0] idx, logic [31:0] count);
    return (idx + 32'd1 >= count) ? 32'd0 : idx + 32'd1;
  endfunction

  // Divider expiry: period 0 and 1 both fire every cycle.
  function automatic logic period_done(logic [31:0] cnt, logic [31:0] period);
    return (period <= 32'd1) || (cnt + 32'd1 >= period);
  endfunction

endpackage

// File: rtl/xyp_bus_if.sv
module xyp_bus_if
  import xyp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hsel,
  input  logic [ADDR_W-1:0]       haddr,
  input  logic [1:0]              htrans,
  input  logic                    hwrite,
  input  logic [DATA_W-1:0]       hwdata,
  output logic [DATA_W-1:0]       hrdata,
  output logic [DATA_W-1:0]       ctrl_q,
  output logic [DATA_W-1:0]       speed_q,
  output logic [NUM_AXES-1:0]     lane_wr,
  output logic                    lane_clr,
  output logic [SAMP_W-1:0]       lane_wdata
);

  // Address phase capture
  logic      aph_valid;
  logic      dph_wr_q, dph_rd_q;
  xyp_word_e dph_word_q;
  logic      unused_addr_bits;

  assign aph_valid        = hsel && htrans[1];
  assign unused_addr_bits = ^{haddr[ADDR_W-1:4], haddr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_wr_q   <= 1'b0;
      dph_rd_q   <= 1'b0;
      dph_word_q <= WORD_CTRL;
    end else begin
      dph_wr_q   <= aph_valid && hwrite;
      dph_rd_q   <= aph_valid && !hwrite;
      dph_word_q <= xyp_word_e'(haddr[3:2]);
    end
  end

  // Data phase decode, brought out as named events
  logic ctrl_wr, speed_wr, port_wr_x, port_wr_y, load_on;

  assign ctrl_wr   = dph_wr_q && (dph_word_q == WORD_CTRL);
  assign speed_wr  = dph_wr_q && (dph_word_q == WORD_SPEED);
  assign port_wr_x = dph_wr_q && (dph_word_q == WORD_XPORT);
  assign port_wr_y = dph_wr_q && (dph_word_q == WORD_YPORT);
  assign load_on   = ctrl_q[BIT_LOAD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      speed_q <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q  <= hwdata;
      if (speed_wr) speed_q <= hwdata;
    end
  end

  assign lane_clr   = ctrl_wr && hwdata[BIT_LOAD] && !load_on;
  assign lane_wr[0] = port_wr_x && load_on;
  assign lane_wr[1] = port_wr_y && load_on;
  assign lane_wdata = hwdata[SAMP_W-1:0];

  always_comb begin
    hrdata = '0;
    if (dph_rd_q) begin
      case (dph_word_q)
        WORD_CTRL:  hrdata = ctrl_q;
        WORD_SPEED: hrdata = speed_q;
        default:    hrdata = '0;
      endcase
    end
  end

  a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(hwdata));

  a_r3_speed_readback: assert property (@(posedge clk) disable iff (!rst_n)
    speed_wr |=> speed_q == $past(hwdata));

  a_r5_write_needs_aphase: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr != '0 || ctrl_wr || speed_wr) |-> $past(hsel && htrans[1] && hwrite));

  a_r7_load_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr_x || port_wr_y) && !ctrl_q[BIT_LOAD] |-> lane_wr == '0);

endmodule

// File: rtl/xyp_sample_lane.sv
module xyp_sample_lane #(
  parameter int SAMP_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              clr,
  input  logic [SAMP_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SAMP_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [SAMP_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (wr) begin
      mem[fill_q] <= wdata;
      fill_q      <= fill_q + 1'b1;
    end
  end

  assign rd_data = mem[rd_idx];

  a_r6_fill_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> fill_q == '0);

  a_r6_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !clr |=> fill_q == $past(fill_q) + 1'b1);

  a_r6_fill_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !clr |=> mem[$past(fill_q)] == $past(wdata));

  a_r7_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr && !clr |=> $stable(fill_q));

endmodule

// File: rtl/xyp_playback.sv
module xyp_playback
  import xyp_pkg::*;
#(
  parameter int SAMP_W   = 16,
  parameter int IDX_W    = 6,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  input  logic [IDX_W-1:0]    count_field,
  input  logic [SAMP_W-1:0]   x_point,
  input  logic [SAMP_W-1:0]   y_point,
  output logic [IDX_W-1:0]    rd_idx,
  output logic [SAMP_W-1:0]   x_out,
  output logic [SAMP_W-1:0]   y_out
);

  localparam logic [31:0] DEPTH = 32'(1 << IDX_W);

  logic [PERIOD_W-1:0] div_q;
  logic [31:0]         count;
  logic                advance;

  assign count   = eff_count(32'(count_field), DEPTH);
  assign advance = run && period_done(32'(div_q), 32'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      rd_idx <= '0;
      x_out  <= '0;
      y_out  <= '0;
    end else if (!run) begin
      div_q <= '0;
    end else if (advance) begin
      div_q  <= '0;
      rd_idx <= IDX_W'(step_index(32'(rd_idx), count));
      x_out  <= x_point;
      y_out  <= y_point;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  a_r8_takes_points: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> x_out == $past(x_point) && y_out == $past(y_point));

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    advance && (32'(rd_idx) + 32'd1 == count) |=> rd_idx == '0);

  a_r9_divider_gap: assert property (@(posedge clk) disable iff (!rst_n)
    run && !advance |=> div_q == $past(div_q) + 1'b1);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(x_out) && $stable(y_out) && $stable(rd_idx));

  a_r10_divider_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> div_q == '0);

endmodule

// File: rtl/xyp_player.sv
module xyp_player
  import xyp_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int SAMP_W   = 16,
  parameter int IDX_W    = 6,
  parameter int PERIOD_W = 16
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready,
  output logic              hresp,
  output logic [SAMP_W-1:0] x_out,
  output logic [SAMP_W-1:0] y_out
);

  localparam int COUNT_LSB = DATA_W - IDX_W;

  logic [DATA_W-1:0]   ctrl_q, speed_q;
  logic [NUM_AXES-1:0] lane_wr;
  logic                lane_clr;
  logic [SAMP_W-1:0]   lane_wdata;
  logic [SAMP_W-1:0]   lane_rd [NUM_AXES];
  logic [IDX_W-1:0]    rd_idx;

  assign hready = 1'b1;
  assign hresp  = 1'b0;

  xyp_bus_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_bus (
    .clk(hclk), .rst_n(hresetn),
    .hsel(hsel), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hwdata(hwdata), .hrdata(hrdata),
    .ctrl_q(ctrl_q), .speed_q(speed_q),
    .lane_wr(lane_wr), .lane_clr(lane_clr), .lane_wdata(lane_wdata)
  );

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_lane
    xyp_sample_lane #(.SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_lane (
      .clk(hclk), .rst_n(hresetn),
      .wr(lane_wr[a]), .clr(lane_clr), .wdata(lane_wdata),
      .rd_idx(rd_idx), .rd_data(lane_rd[a])
    );
  end

  xyp_playback #(.SAMP_W(SAMP_W), .IDX_W(IDX_W), .PERIOD_W(PERIOD_W)) u_play (
    .clk(hclk), .rst_n(hresetn),
    .run(ctrl_q[BIT_RUN]),
    .period(speed_q[PERIOD_W-1:0]),
    .count_field(ctrl_q[DATA_W-1:COUNT_LSB]),
    .x_point(lane_rd[0]), .y_point(lane_rd[1]),
    .rd_idx(rd_idx), .x_out(x_out), .y_out(y_out)
  );

  a_r1_no_wait: assert property (@(posedge hclk) disable iff (!hresetn)
    hsel |-> hready && !hresp);

endmodule

// File: tb/xyp_player_bench.sv
`timescale 1ns/1ps
module xyp_player_bench;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        hsel = 1'b0;
  logic [7:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hready, hresp;
  logic [15:0] x_out, y_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the tables and play pointer
  logic [15:0] mx [64];
  logic [15:0] my [64];
  int ridx = 0;
  int cnt_model = 4;
  logic [15:0] ex = '0, ey = '0;

  always #2 hclk = ~hclk;

  xyp_player u_xyp_player (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp), .x_out(x_out), .y_out(y_out)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(int word, logic [31:0] data, logic [1:0] tr = 2'b10);
    hsel = 1'b1; haddr = 8'(word << 2); htrans = tr; hwrite = 1'b1;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = data;
    @(negedge hclk);
  endtask

  task automatic bus_read(int word, output logic [31:0] data);
    hsel = 1'b1; haddr = 8'(word << 2); htrans = 2'b10; hwrite = 1'b0;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00;
    data = hrdata;
  endtask

  function automatic logic [31:0] ctrl_word(bit run, bit load, int count);
    return (32'(count) << 26) | (32'(load) << 1) | 32'(run);
  endfunction

  task automatic model_advance();
    ex = mx[ridx]; ey = my[ridx];
    ridx = (ridx + 1 >= cnt_model) ? 0 : ridx + 1;
  endtask

  task automatic chk_out(string req);
    chk(req, 32'(x_out), 32'(ex));
    chk(req, 32'(y_out), 32'(ey));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 x_out", 32'(x_out), 0);
    chk("R1 y_out", 32'(y_out), 0);
    chk("R1 hready", 32'(hready), 1);
    chk("R1 hresp", 32'(hresp), 0);
    bus_read(0, d); chk("R1 ctrl", d, 0);
    bus_read(1, d); chk("R1 speed", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(0, 32'hA400_0006);
    bus_read(0, d); chk("R2 ctrl readback", d, 32'hA400_0006);
    bus_write(0, 32'h0);
    bus_read(0, d); chk("R2 ctrl cleared", d, 0);
    bus_write(1, 32'h5A5A_0001);
    bus_read(1, d); chk("R3 speed readback", d, 32'h5A5A_0001);
    bus_read(2, d); chk("R4 xport read", d, 0);
    bus_read(3, d); chk("R4 yport read", d, 0);
    bus_write(1, 32'hDEAD_0007, 2'b00);
    bus_read(1, d); chk("R5 idle write ignored", d, 32'h5A5A_0001);
  endtask

  task automatic t_load();
    bus_write(0, ctrl_word(0, 1, 0));
    bus_write(2, 32'h4000); mx[0] = 16'h4000;
    bus_write(2, 32'h9000); mx[1] = 16'h9000;
    bus_write(2, 32'h7FFF); mx[2] = 16'h7FFF;
    bus_write(3, 32'hC000); my[0] = 16'hC000;
    bus_write(3, 32'h7000); my[1] = 16'h7000;
    bus_write(3, 32'h7000); my[2] = 16'h7000;
    bus_write(3, 32'h9000); my[3] = 16'h9000;
    bus_write(0, ctrl_word(0, 0, 0));
    // R7: would land in X slot 3 if not ignored; slot 3 stays 0
    bus_write(2, 32'h7777);
    chk("R7 no output change", 32'(x_out), 0);
  endtask

  task automatic t_play_fast();
    bus_write(1, 32'd1);
    bus_write(0, ctrl_word(1, 0, 4));
    for (int k = 0; k < 6; k++) begin
      @(negedge hclk);
      model_advance();
      chk_out("R8 sequence and R7 slot3");
    end
    // two advances occur during the stop transfer at period 1 (R9 timing)
    bus_write(0, ctrl_word(0, 0, 4));
    model_advance(); model_advance();
    chk_out("R9 stop takes effect after data edge");
    repeat (10) @(negedge hclk);
    chk_out("R10 frozen while stopped");
  endtask

  task automatic t_play_slow();
    bus_write(1, 32'd3);
    bus_write(0, ctrl_word(1, 0, 4));
    for (int k = 0; k < 3; k++) begin
      repeat (2) @(negedge hclk);
      chk_out("R9 no advance before period");
      @(negedge hclk);
      model_advance();
      chk_out("R10 resume and R9 period");
    end
    bus_write(0, ctrl_word(0, 0, 4));
    repeat (5) @(negedge hclk);
    chk_out("R10 stop at period 3");
  endtask

  task automatic t_reload();
    bus_write(0, ctrl_word(0, 1, 0));
    bus_write(2, 32'h8001); mx[0] = 16'h8001;
    bus_write(3, 32'h1234); my[0] = 16'h1234;
    bus_write(0, ctrl_word(1, 0, 4));
    for (int k = 0; k < 4; k++) begin
      repeat (3) @(negedge hclk);
      model_advance();
      chk_out("R6 pointer restart on load rise");
    end
    bus_write(0, ctrl_word(0, 0, 4));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mx[i] = '0; my[i] = '0; end
    repeat (3) @(negedge hclk);
    hresetn = 1'b1;
    @(negedge hclk);
    t_reset();
    t_regs();
    t_load();
    t_play_fast();
    t_play_slow();
    t_reload();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge hclk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule